// File: doc/BRIEF.md
# Square-Wave Interval Timer with Count Snapshot

This block is a single 16-bit down-counting interval timer placed behind a small byte-wide register port. Software writes a 16-bit reload value as two bytes, picks the square-wave mode and a count source, and sets a run bit. While it runs, the counter steps down once per count step. A count step is either a pulse on the external `tick` enable or, if the internal source is chosen, every clock. When the count is spent, the counter reloads and the output pin changes level. One full output cycle therefore spans two expiries.

Only the high-to-low change of the output raises the interrupt-pending flag, which happens once per two expiries. The active-low interrupt pin is driven while the flag is set, the interrupt enable is on and the routing bit lets the interrupt through. Software clears the flag with an acknowledge write to the status register.

The count is never read live. A latch command copies the counter into a holding register, and the two count bytes read from that copy. Register access is split into banks, and the bank is chosen by the top two bits of the status register. The timer registers are in bank 0 and the interrupt control registers are in bank 1.

Top module: `sqw_timer`

## Requirements
- R1: After reset the status register (address 0) reads 0x10, `tmr_out` is 1, `irq_n` is 1, and the control, count and interrupt control registers read 0.
- R2: The reload value is set by byte writes in bank 0: the high byte at address 2 and the low byte at address 3. Counting starts from the reload value. The output changes level every reload+1 count steps. A count step is a clock with `tick` high when control bit 3 is 0, and every clock when control bit 3 is 1.
- R3: `tmr_out` changes level only at an expiry, meaning a count step taken while the count is 0. Between expiries it holds its level.
- R4: Status bit 5 (pending) is set on each high-to-low change of `tmr_out`, and never on a low-to-high change. It stays set until it is acknowledged.
- R5: A write to address 0 with bit 5 set clears the pending flag. Any bank reached through that write is still selected.
- R6: `irq_n` is 0 exactly when all three hold: pending is set, bank 1 address 1 bit 7 (enable) is 1, and bank 1 address 2 bit 4 (routing block) is 0.
- R7: The control register is bank 0 address 1. Bit 0 is run. Bits 2:1 are the mode, and only the value 10 (square wave) lets the counter step. Bit 3 selects the count source. A write that sets run while it was clear loads the counter from the reload value. While run is clear the count is frozen and ticks have no effect. The register reads back bits 3:0.
- R8: Writing the control register with bit 6 set copies the current count into the holding register. Address 2 reads the held high byte and address 3 reads the held low byte. Those reads stay unchanged until the next latch command, even while the counter runs. A latch issued while stopped captures the frozen count.
- R9: Status bits 7:6 select the bank. Bank 0 exposes control and count at addresses 1 to 3. Bank 1 exposes the enable at address 1 and the routing bit at address 2. Every other bank and address pair reads 0 and ignores writes.
- R10: Status bit 4 reads the present level of `tmr_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | External count enable, one count step per clock it is high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tmr_out | output | 1 | Square-wave timer output |
| irq_n | output | 1 | Active-low interrupt |

## Verification
An expiry detected on the wrong count shows up as a `tmr_out` edge that arrives early or late. That error is visible on the first expiry after a start, which is reload+1 count steps away. A pending flag that follows the wrong output edge changes `irq_n` and status bit 5 half an output cycle out of place. A held count that follows the live counter appears as soon as count steps pass between two reads of the same byte. Bank decode errors show up on the very next read.

// File: rtl/sqw_timer.sv
module sqw_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       tmr_out,
  output logic       irq_n
);

  logic [1:0]  bank_q;
  logic [3:0]  ctrl_q;
  logic [15:0] reload_q, cnt_q, hold_q;
  logic        out_q, pend_q, ien_q, route_q;

  wire b0      = (bank_q == 2'd0);
  wire b1      = (bank_q == 2'd1);
  wire wr_stat = wr_en && addr == 2'd0;
  wire wr_ctrl = wr_en && b0 && addr == 2'd1;
  wire start   = wr_ctrl && wdata[0] && !ctrl_q[0];
  wire step    = ctrl_q[0] && ctrl_q[2:1] == 2'b10 && (ctrl_q[3] || tick);
  wire expire  = step && cnt_q == 16'd0 && !start;
  wire fall    = expire && out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q   <= 2'd0;
      ctrl_q   <= 4'd0;
      reload_q <= 16'd0;
      cnt_q    <= 16'd0;
      hold_q   <= 16'd0;
      out_q    <= 1'b1;
      pend_q   <= 1'b0;
      ien_q    <= 1'b0;
      route_q  <= 1'b0;
    end else begin
      if (wr_stat) bank_q <= wdata[7:6];
      if (wr_ctrl) begin
        ctrl_q <= wdata[3:0];
        if (wdata[6]) hold_q <= cnt_q;
      end
      if (wr_en && b0 && addr == 2'd2) reload_q[15:8] <= wdata;
      if (wr_en && b0 && addr == 2'd3) reload_q[7:0]  <= wdata;
      if (wr_en && b1 && addr == 2'd1) ien_q   <= wdata[7];
      if (wr_en && b1 && addr == 2'd2) route_q <= wdata[4];
      if (start)       cnt_q <= reload_q;
      else if (expire) cnt_q <= reload_q;
      else if (step)   cnt_q <= cnt_q - 16'd1;
      if (expire) out_q <= !out_q;
      if (fall) pend_q <= 1'b1;
      else if (wr_stat && wdata[5]) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      2'd0: rdata = {bank_q, pend_q, out_q, 4'h0};
      2'd1: if (b0) rdata = {4'h0, ctrl_q};
            else if (b1) rdata = {ien_q, 7'h00};
      2'd2: if (b0) rdata = hold_q[15:8];
            else if (b1) rdata = {3'b000, route_q, 4'h0};
      default: if (b0) rdata = hold_q[7:0];
    endcase
  end

  assign tmr_out = out_q;
  assign irq_n   = !(pend_q && ien_q && !route_q);

endmodule

// File: rtl/sqw_timer_chk.sv
module sqw_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  addr,
  input logic [7:0]  wdata,
  input logic        tmr_out,
  input logic        pend,
  input logic        run,
  input logic [1:0]  bank,
  input logic [15:0] cnt,
  input logic [15:0] hold
);

  p_pend_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $fell(tmr_out));

  p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && wdata[5]) |=> (!pend || $fell(tmr_out)));

  p_out_at_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tmr_out) |-> $past(cnt) == 16'd0);

  p_stop_freezes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && bank == 2'd0 && addr == 2'd1)) |=> $stable(cnt));

  p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bank == 2'd0 && addr == 2'd1 && wdata[6]) |=> $stable(hold));

endmodule

bind sqw_timer sqw_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .tmr_out(tmr_out), .pend(pend_q), .run(ctrl_q[0]), .bank(bank_q),
  .cnt(cnt_q), .hold(hold_q)
);

// File: tb/sim_sqw_timer.sv
module sim_sqw_timer;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic tmr_out, irq_n;
  int checks = 0, errors = 0;
  logic [7:0] v;

  sqw_timer u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out), .irq_n(irq_n));

  always #4 clk = !clk;

  // {wr, addr, data, expected read}
  localparam logic [18:0] VEC [22] = '{
    {1'b0, 2'd0, 8'h00, 8'h10}, {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h00}, {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h40, 8'h00}, {1'b0, 2'd0, 8'h00, 8'h50},
    {1'b0, 2'd1, 8'h00, 8'h00}, {1'b1, 2'd1, 8'h80, 8'h00},
    {1'b0, 2'd1, 8'h00, 8'h80}, {1'b1, 2'd2, 8'h10, 8'h00},
    {1'b0, 2'd2, 8'h00, 8'h10}, {1'b0, 2'd3, 8'h00, 8'h00},
    {1'b1, 2'd2, 8'h00, 8'h00}, {1'b0, 2'd2, 8'h00, 8'h00},
    {1'b1, 2'd0, 8'h80, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h90}, {1'b1, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'h0A, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h0A},
    {1'b1, 2'd1, 8'h00, 8'h00}, {1'b0, 2'd1, 8'h00, 8'h00}
  };

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #20 rst_n = 1;
    @(negedge clk);
    chk("R1 tmr_out", tmr_out, 1);
    chk("R1 irq_n", irq_n, 1);
    for (int i = 0; i < 22; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][17:16], v);
        chk($sformatf("R1/R9 table row %0d", i), v, VEC[i][7:0]);
      end
    end
    // bank 0, enable on, routing open
    wr(2, 8'h00); wr(3, 8'h02); wr(1, 8'h05);
    ticks(2);
    chk("R3 out before expiry", tmr_out, 1);
    chk("R4 no early irq", irq_n, 1);
    ticks(1);
    chk("R2 out low after reload+1", tmr_out, 0);
    chk("R6 irq asserted", irq_n, 0);
    rd(0, v); chk("R4 R10 status pending, out low", v, 8'h20);
    ticks(3);
    chk("R3 out high again", tmr_out, 1);
    rd(0, v); chk("R4 rise keeps pending", v, 8'h30);
    wr(0, 8'h20);
    rd(0, v); chk("R5 ack clears", v, 8'h10);
    chk("R5 irq released", irq_n, 1);
    ticks(2);
    rd(0, v); chk("R4 rise sets nothing", v, 8'h10);
    ticks(1);
    chk("R4 second fall irq", irq_n, 0);
    wr(0, 8'h40); wr(2, 8'h10);
    chk("R6 routing blocks pin", irq_n, 1);
    rd(0, v); chk("R6 pending kept while blocked", v, 8'h60);
    wr(2, 8'h00);
    chk("R6 routing open", irq_n, 0);
    wr(1, 8'h00);
    chk("R6 enable off", irq_n, 1);
    wr(1, 8'h80);
    wr(0, 8'h20);
    chk("R5 ack with bank 0", irq_n, 1);
    rd(1, v); chk("R5 bank 0 selected", v, 8'h05);
    // latch
    wr(2, 8'h12); wr(3, 8'h34); wr(1, 8'h04); wr(1, 8'h05);
    ticks(5);
    wr(1, 8'h04);
    ticks(3);
    wr(1, 8'h44);
    rd(2, v); chk("R8 stopped latch hi", v, 8'h12);
    rd(3, v); chk("R7 R8 stopped latch lo", v, 8'h2F);
    ticks(2);
    rd(3, v); chk("R8 reread same", v, 8'h2F);
    wr(1, 8'h05);
    ticks(3);
    wr(1, 8'h45);
    rd(3, v); chk("R8 running latch", v, 8'h31);
    ticks(4);
    rd(3, v); chk("R8 held not live", v, 8'h31);
    wr(1, 8'h45);
    rd(3, v); chk("R8 relatch", v, 8'h2D);
    // mode other than square wave
    wr(1, 8'h04); wr(1, 8'h01);
    ticks(4);
    wr(1, 8'h41);
    rd(3, v); chk("R7 wrong mode no count", v, 8'h34);
    rd(1, v); chk("R7 ctrl readback", v, 8'h01);
    // internal count source, reload 4; out is low here
    wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h04); wr(0, 8'h20);
    wr(1, 8'h0D);
    repeat (4) @(negedge clk);
    chk("R2 internal before expiry", tmr_out, 0);
    @(negedge clk);
    chk("R2 internal expiry", tmr_out, 1);
    chk("R4 rise no irq", irq_n, 1);
    repeat (5) @(negedge clk);
    chk("R2 internal second expiry", tmr_out, 0);
    chk("R4 fall irq", irq_n, 0);
    wr(1, 8'h00);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule